// File: doc/BRIEF.md
# Multi-view inter-thread FIFO cell

This block is a single storage cell that several hardware threads share to pass data between them. Inside it is a small queue. Each access picks one of four views, and each view treats that queue differently. The two empty/full views push on a write and pop the oldest entry on a read. The synchronized variant stalls the requesting thread when it cannot complete. The try variant never stalls: it drops the write or returns zero instead. The bypass view lets software look at the oldest entry, or patch the newest entry in place, without any side effect. The control view exposes a small tag that shows the fill state. Through that tag, software can flush the queue.

The cell takes at most one access per cycle. The access comes with a thread number. Read data and the stall indication are combinational in the cycle of the access, and all state changes at the next rising clock edge. When a synchronized access stalls, the cell records the thread in a per-thread waiting bitmap and leaves the queue untouched. When the condition that thread waits on is resolved, the cell clears the bit and gives that thread a one-cycle wake pulse. The thread then has to issue its access again.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the queue is empty, `blocked_o` and `wake_o` are zero, and a control-view read returns the tag value 5 (empty=1, full=0, type=1).
- R2: In both empty/full views (view 2 synchronized, view 3 try), a write that is not refused pushes `wdata_i`, and a read that is not refused returns and removes the oldest entry, in first-in first-out order across pointer wrap.
- R3: The tag fields are: bit 0 empty, bit 1 full, bit 2 cell-is-FIFO; all higher bits read zero. Empty and full follow the fill level after every push, pop and flush, and full means DEPTH entries are held.
- R4: A synchronized-view (view 2) read of an empty queue raises `block_o` in the same cycle and returns zero. From the next cycle on, the thread's bit in `blocked_o` is set and the queue is unchanged.
- R5: A synchronized-view write to a full queue raises `block_o`, discards the data, and sets the thread's `blocked_o` bit from the next cycle.
- R6: The try view (view 3) never raises `block_o`. A write to a full queue is dropped without any trace, and a read of an empty queue returns zero and removes nothing.
- R7: A bypass-view (view 0) read returns the oldest entry without removing it, or zero when the queue is empty. A bypass write replaces the newest entry in place, and does nothing when the queue is empty. Neither kind of bypass access changes the tag or raises `block_o`.
- R8: A control-view (view 1) read returns the tag. A control write whose bit 0 is 1 empties the queue. A control write whose bit 0 is 0 has no effect, and the type bit cannot be written. The control view never raises `block_o`.
- R9: After a push, every thread that was waiting to read is released. After a pop or a flush, every thread that was waiting to write is released. A released thread's `blocked_o` bit clears, and its `wake_o` bit is high for exactly the cycle after the releasing access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access valid this cycle |
| view_i | input | 2 | 0 bypass, 1 control, 2 empty/full synchronized, 3 empty/full try |
| we_i | input | 1 | 1 write, 0 read |
| tid_i | input | $clog2(NTHR) | Requesting thread number |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data (zero for writes, idle cycles and refused reads) |
| block_o | output | 1 | The access this cycle stalls its thread |
| blocked_o | output | NTHR | Threads currently waiting on the cell |
| wake_o | output | NTHR | One-cycle release pulse per thread |

## Verification
The bench builds the cell with DEPTH=3, DW=16 and NTHR=4. A depth that is not a power of two makes the read and write pointers wrap through an explicit compare rather than a natural rollover. The cell therefore passes through the full, empty and wrapped states many times within a few accesses. Four threads allow readers and writers to wait at the same time as other threads succeed or are dropped by the try view. A narrower data path keeps the tag bits visibly apart from the payload values.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;
  typedef enum logic [1:0] {
    VIEW_BYPASS  = 2'd0,
    VIEW_CTRL    = 2'd1,
    VIEW_EF_SYNC = 2'd2,
    VIEW_EF_TRY  = 2'd3
  } view_e;

  localparam int TAG_EMPTY_BIT = 0;
  localparam int TAG_FULL_BIT  = 1;
  localparam int TAG_FIFO_BIT  = 2;

  typedef struct packed {
    logic push;
    logic pop;
    logic ovr;
    logic flush;
    logic rd_wait;
    logic wr_wait;
  } cell_op_t;
endpackage

// File: rtl/itc_cell_store.sv
module itc_cell_store #(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          ovr_i,
  input  logic          flush_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q, newest;
  logic [CW-1:0] count_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign newest  = (wr_ptr_q == '0) ? PW'(DEPTH - 1) : wr_ptr_q - 1'b1;
  assign head_o  = mem_q[rd_ptr_q];
  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign count_o = count_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if ((push_i && wr_ptr_q == PW'(g)) || (ovr_i && newest == PW'(g))) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else if (push_i) begin
      wr_ptr_q <= ptr_inc(wr_ptr_q);
      count_q  <= count_q + 1'b1;
    end else if (pop_i) begin
      rd_ptr_q <= ptr_inc(rd_ptr_q);
      count_q  <= count_q - 1'b1;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_count_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  p_ovr_nonempty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |-> !empty_o);
  p_flush_empties_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/itc_cell_view.sv
module itc_cell_view
  import itc_cell_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          req_i,
  input  view_e         view_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          empty_i,
  input  logic          full_i,
  input  logic [DW-1:0] head_i,
  output cell_op_t      op_o,
  output logic [DW-1:0] rdata_o,
  output logic          block_o
);
  logic [DW-1:0] tag;

  always_comb begin
    tag = '0;
    tag[TAG_EMPTY_BIT] = empty_i;
    tag[TAG_FULL_BIT]  = full_i;
    tag[TAG_FIFO_BIT]  = 1'b1;
  end

  always_comb begin
    op_o    = '0;
    rdata_o = '0;
    block_o = 1'b0;
    if (req_i) begin
      unique case (view_i)
        VIEW_BYPASS: begin
          if (we_i) op_o.ovr = !empty_i;
          else      rdata_o  = empty_i ? '0 : head_i;
        end
        VIEW_CTRL: begin
          if (we_i) op_o.flush = wdata_i[TAG_EMPTY_BIT];
          else      rdata_o    = tag;
        end
        VIEW_EF_SYNC, VIEW_EF_TRY: begin
          if (we_i) begin
            op_o.push    = !full_i;
            op_o.wr_wait = full_i && (view_i == VIEW_EF_SYNC);
          end else begin
            op_o.pop     = !empty_i;
            op_o.rd_wait = empty_i && (view_i == VIEW_EF_SYNC);
            rdata_o      = empty_i ? '0 : head_i;
          end
          block_o = op_o.rd_wait || op_o.wr_wait;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/itc_cell_waits.sv
module itc_cell_waits #(
  parameter int NTHR  = 4,
  localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TIDW-1:0] tid_i,
  input  logic            rd_wait_i,
  input  logic            wr_wait_i,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic            flush_i,
  output logic [NTHR-1:0] blocked_o,
  output logic [NTHR-1:0] wake_o
);
  logic [NTHR-1:0] rd_q, wr_q, wake_q, sel, rel_rd, rel_wr;

  always_comb begin
    sel = '0;
    sel[tid_i] = 1'b1;
  end

  assign rel_rd = push_i ? rd_q : '0;
  assign rel_wr = (pop_i || flush_i) ? wr_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      wake_q <= '0;
    end else begin
      rd_q   <= (rd_q & ~rel_rd) | (rd_wait_i ? sel : '0);
      wr_q   <= (wr_q & ~rel_wr) | (wr_wait_i ? sel : '0);
      wake_q <= rel_rd | rel_wr;
    end
  end

  assign blocked_o = rd_q | wr_q;
  assign wake_o    = wake_q;

  p_wake_was_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o & ~$past(blocked_o)) == '0);
  p_push_frees_readers_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (rd_q & $past(rd_q)) == '0);
  p_pop_frees_writers_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i || flush_i) |=> (wr_q & $past(wr_q)) == '0);
  p_wait_sets_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_wait_i || wr_wait_i) |=> blocked_o[$past(tid_i)]);
endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell
  import itc_cell_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 32,
  parameter int NTHR  = 4,
  localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [1:0]      view_i,
  input  logic            we_i,
  input  logic [TIDW-1:0] tid_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            block_o,
  output logic [NTHR-1:0] blocked_o,
  output logic [NTHR-1:0] wake_o
);
  cell_op_t      op;
  view_e         view;
  logic [DW-1:0] head;
  logic          empty, full;
  logic [CW-1:0] count;

  assign view = view_e'(view_i);

  itc_cell_view #(.DW(DW)) u_view (
    .req_i   (req_i),
    .view_i  (view),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .empty_i (empty),
    .full_i  (full),
    .head_i  (head),
    .op_o    (op),
    .rdata_o (rdata_o),
    .block_o (block_o)
  );

  itc_cell_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (op.push),
    .pop_i   (op.pop),
    .ovr_i   (op.ovr),
    .flush_i (op.flush),
    .wdata_i (wdata_i),
    .head_o  (head),
    .empty_o (empty),
    .full_o  (full),
    .count_o (count)
  );

  itc_cell_waits #(.NTHR(NTHR)) u_waits (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tid_i     (tid_i),
    .rd_wait_i (op.rd_wait),
    .wr_wait_i (op.wr_wait),
    .push_i    (op.push),
    .pop_i     (op.pop),
    .flush_i   (op.flush),
    .blocked_o (blocked_o),
    .wake_o    (wake_o)
  );

  p_try_never_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && view == VIEW_EF_TRY) |-> !block_o);
  p_block_only_sync_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |-> (req_i && view == VIEW_EF_SYNC));
  p_bypass_keeps_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && view == VIEW_BYPASS) |=> $stable(count));
  p_blocked_keeps_queue_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_o |=> $stable(count));
  p_ctrl_never_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && view == VIEW_CTRL) |-> !block_o);
endmodule

// File: tb/sim_itc_fifo_cell.sv
module sim_itc_fifo_cell;
  localparam int DEPTH = 3;
  localparam int DW    = 16;
  localparam int NTHR  = 4;
  localparam int TIDW  = $clog2(NTHR);

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_i = 1'b0;
  logic [1:0]      view_i = 2'd0;
  logic            we_i = 1'b0;
  logic [TIDW-1:0] tid_i = '0;
  logic [DW-1:0]   wdata_i = '0;
  logic [DW-1:0]   rdata_o;
  logic            block_o;
  logic [NTHR-1:0] blocked_o, wake_o;

  always #5 clk = ~clk;

  itc_fifo_cell #(.DEPTH(DEPTH), .DW(DW), .NTHR(NTHR)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .view_i(view_i), .we_i(we_i),
    .tid_i(tid_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .block_o(block_o),
    .blocked_o(blocked_o), .wake_o(wake_o)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [DW-1:0]   exp_rd_q[$];
  logic            exp_blk_q[$];
  logic [NTHR-1:0] exp_bl_q[$];
  logic [NTHR-1:0] exp_wk_q[$];
  string           exp_tag_q[$];

  // reference state
  logic [DW-1:0]   mq[$];
  logic [NTHR-1:0] m_rw = '0, m_ww = '0, m_wk = '0;

  task automatic acc(input logic r, input logic [1:0] v, input logic w,
                     input int t, input logic [DW-1:0] d, input string rq);
    logic [DW-1:0]   rd;
    logic            blk;
    logic [NTHR-1:0] nwk;
    logic            emp, ful;
    @(negedge clk);
    req_i = r; view_i = v; we_i = w; tid_i = TIDW'(t); wdata_i = d;
    rd = '0; blk = 1'b0; nwk = '0;
    emp = (mq.size() == 0);
    ful = (mq.size() == DEPTH);
    exp_bl_q.push_back(m_rw | m_ww);
    exp_wk_q.push_back(m_wk);
    if (r) begin
      case (v)
        2'd0: if (!w) rd = emp ? '0 : mq[0];
              else if (!emp) mq[mq.size()-1] = d;
        2'd1: if (!w) rd = DW'({1'b1, ful, emp});
              else if (d[0]) begin mq.delete(); nwk |= m_ww; m_ww = '0; end
        default: begin
          if (!w) begin
            if (emp) begin
              if (v == 2'd2) begin blk = 1'b1; m_rw[t] = 1'b1; end
            end else begin
              rd = mq.pop_front(); nwk |= m_ww; m_ww = '0;
            end
          end else begin
            if (ful) begin
              if (v == 2'd2) begin blk = 1'b1; m_ww[t] = 1'b1; end
            end else begin
              mq.push_back(d); nwk |= m_rw; m_rw = '0;
            end
          end
        end
      endcase
    end
    m_wk = nwk;
    exp_rd_q.push_back(rd);
    exp_blk_q.push_back(blk);
    exp_tag_q.push_back(rq);
  endtask

  // monitor: samples mid-low-phase, before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_rd_q.size() > 0) begin
        logic [DW-1:0] erd; logic eb; logic [NTHR-1:0] ebl, ewk; string tg;
        erd = exp_rd_q.pop_front(); eb = exp_blk_q.pop_front();
        ebl = exp_bl_q.pop_front(); ewk = exp_wk_q.pop_front();
        tg = exp_tag_q.pop_front();
        compared++;
        if (rdata_o !== erd || block_o !== eb || blocked_o !== ebl || wake_o !== ewk) begin
          mismatched++;
          $display("FAIL %s: rdata=%h block=%b blocked=%b wake=%b expected rdata=%h block=%b blocked=%b wake=%b",
                   tg, rdata_o, block_o, blocked_o, wake_o, erd, eb, ebl, ewk);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state and tag
    acc(0, 0, 0, 0, 0, "R1 idle after reset");
    acc(1, 1, 0, 0, 0, "R1 tag after reset");
    // R4 sync read on empty stalls thread 1
    acc(1, 2, 0, 1, 0, "R4 sync read empty");
    acc(0, 0, 0, 0, 0, "R4 blocked bit set");
    // R9 push releases reader; R2 try write pushes
    acc(1, 3, 1, 0, 16'h00a1, "R9 push wakes reader");
    acc(0, 0, 0, 0, 0, "R9 wake pulse");
    acc(0, 0, 0, 0, 0, "R9 wake one cycle");
    acc(1, 2, 1, 0, 16'h00b2, "R2 sync push");
    acc(1, 2, 1, 0, 16'h00c3, "R2 sync push to full");
    acc(1, 1, 0, 0, 0, "R3 tag full");
    // R5 sync write on full stalls; R6 try write on full dropped
    acc(1, 2, 1, 2, 16'h0dd4, "R5 sync write full");
    acc(1, 3, 1, 3, 16'h0ee5, "R6 try write full dropped");
    // R7 bypass peek and overwrite newest
    acc(1, 0, 0, 1, 0, "R7 bypass read oldest");
    acc(1, 0, 1, 1, 16'h5a5a, "R7 bypass overwrite newest");
    acc(1, 1, 0, 1, 0, "R7 tag unchanged by bypass");
    // R2 pops in order; pop releases writer (R9)
    acc(1, 2, 0, 0, 0, "R2 pop oldest wakes writer");
    acc(1, 3, 0, 0, 0, "R2 try pop");
    acc(1, 2, 0, 0, 0, "R7 pop overwritten entry");
    acc(1, 1, 0, 0, 0, "R3 tag empty again");
    acc(1, 3, 0, 1, 0, "R6 try read empty returns zero");
    acc(1, 0, 0, 1, 0, "R7 bypass read empty");
    acc(1, 0, 1, 1, 16'h7777, "R7 bypass write empty ignored");
    acc(1, 1, 0, 1, 0, "R7 tag after ignored write");
    // wrap through the non power of two depth
    for (int i = 0; i < 7; i++) begin
      acc(1, 3, 1, i % NTHR, DW'(16'h1000 + i), "R2 wrap push");
      acc(1, 2, 1, i % NTHR, DW'(16'h2000 + i), "R2 wrap push");
      acc(1, 2, 0, i % NTHR, 0, "R2 wrap pop");
      acc(1, 3, 0, i % NTHR, 0, "R2 wrap pop");
    end
    // R8 control writes: bit0=0 no effect, type bit unwritable, flush wakes writers
    acc(1, 2, 1, 0, 16'h0301, "R2 refill");
    acc(1, 1, 1, 0, 16'hfffe, "R8 ctrl write bit0 clear");
    acc(1, 1, 0, 0, 0, "R8 tag after no-op write");
    acc(1, 3, 0, 0, 0, "R8 data kept after no-op write");
    for (int i = 0; i < DEPTH; i++) acc(1, 2, 1, 0, DW'(16'h0400 + i), "R3 fill");
    acc(1, 2, 1, 3, 16'h0bad, "R5 writer waits");
    acc(1, 2, 1, 1, 16'h0bad, "R5 second writer waits");
    acc(1, 1, 1, 0, 16'h0001, "R8 flush wakes writers");
    acc(1, 1, 0, 0, 0, "R9 wake after flush");
    acc(1, 3, 0, 0, 0, "R8 queue empty after flush");
    // mixed waiters: readers on empty, one push releases both
    acc(1, 2, 0, 2, 0, "R4 reader t2 waits");
    acc(1, 2, 0, 3, 0, "R4 reader t3 waits");
    acc(1, 2, 1, 0, 16'h0999, "R9 push releases both readers");
    acc(1, 2, 0, 3, 0, "R9 reissued read");
    acc(0, 0, 0, 0, 0, "R1 idle end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule